// File: doc/BRIEF.md
# Flash Byte-Programming and Erase Sequencer

This block is a behavioural model of the parallel programming port of a small on-chip code flash. The default array is 4096 bytes, addresses 000H to FFFH. An external programmer drives an address, a data byte, a three-bit mode code, a high-voltage enable flag and an active-low program strobe. The block writes single bytes with a self-timed busy interval and supports data polling while that interval runs. It also erases the whole array with a long strobe hold, reads code back for verification, sets two protection bits and returns fixed identification bytes.

A byte cell can only move from the erased value FFH to a programmed value, so rewriting a cell needs a chip erase first. The two write durations are parameters counted in clock cycles. `WRITE_CYC` defaults to 1.5 ms at 200 MHz and `ERASE_CYC` to 10 ms at 200 MHz. A testbench can set both much shorter.

The port works at pin level and has no handshake. `rdy_o` is the only flow control. While it is low, any strobe or erase hold is dropped and is not queued, so the programmer must wait for `rdy_o` high before it issues the next command. Read data is registered: `dout_o` shows the result for the mode and address that were present at the previous rising clock edge.

Top module: `flash_prog_seq`

## Requirements
- R1: Reset (`rst_n` low) leaves every byte erased (reads FFH), both protection bits clear, `rdy_o` high and `dout_o` at 00H.
- R2: Write mode is code 1. When `prog_n_i` goes from high to low in write mode while `hv_en_i` is 1 and `rdy_o` is high, the block latches the address and data. `rdy_o` is then low for exactly `WRITE_CYC` cycles, starting one cycle after the clock edge that saw the falling strobe.
- R3: Read mode is code 2. While busy, a read at the latched address returns the complement of the latched bit 7 in bit 7, with bits 6:0 at 0. A read at any other address, or in any other mode, returns 00H while busy.
- R4: When the busy interval ends, a read of a blank cell returns the written byte. Each read result appears on `dout_o` one clock after its mode and address are sampled.
- R5: A write to a cell that is not blank still runs the full `WRITE_CYC` busy interval, and the cell keeps its old value.
- R6: Erase mode is code 3. Holding `prog_n_i` low with `hv_en_i` at 1 for `ERASE_CYC` consecutive sampled cycles sets every byte to FFH and clears both protection bits. A hold that is one cycle shorter changes nothing.
- R7: A strobe or erase hold that arrives while `rdy_o` is low has no effect. The running interval is neither restarted nor extended, and the second address is not written.
- R8: With `hv_en_i` at 0, write, protect and erase commands do nothing: `rdy_o` stays high and the contents stay as they were.
- R9: Protect modes are code 4 (bit A) and code 5 (bit B). A strobe in either mode runs one `WRITE_CYC` busy interval and then sets that bit. While either bit is set, code reads return 00H. The protection bits themselves are never returned.
- R10: Identity mode is code 6. In this mode, address 030H returns 1EH, 031H returns 51H, and 032H returns FFH when `VPP_HIGH`=1 (05H otherwise). Every other address returns 00H, and the protection bits do not affect these reads.
- R11: Mode codes 0 and 7 return 00H and start nothing. A strobe in read mode starts nothing either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | Byte address |
| din_i | input | 8 | Byte to program |
| mode_i | input | 3 | Command code (0 idle, 1 write, 2 read, 3 erase, 4/5 protect, 6 identity) |
| hv_en_i | input | 1 | High-voltage enable; gates write, protect and erase |
| prog_n_i | input | 1 | Active-low program strobe |
| dout_o | output | 8 | Registered read data |
| rdy_o | output | 1 | High when idle, low during a timed write or protect interval |

## Verification
The bench times the busy interval to the exact cycle. A counter that is off by one shows up as a busy length of `WRITE_CYC`±1. A second strobe arriving mid-interval would lengthen the interval or write a second address. The polling test writes a byte whose bit 7 is 0, so a design that returned true data early, or forgot to invert the bit, gives a value different from 80H. Erase holds of `ERASE_CYC`-1 and `ERASE_CYC` cycles separate a correct threshold from an early one. Other cases cover rewriting a programmed cell, commands with high voltage off, and reads under protection. Each of these would otherwise overwrite data, start a spurious busy interval, or leak code contents.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;
  typedef enum logic [2:0] {
    MD_IDLE  = 3'd0,
    MD_WRITE = 3'd1,
    MD_READ  = 3'd2,
    MD_ERASE = 3'd3,
    MD_LOCKA = 3'd4,
    MD_LOCKB = 3'd5,
    MD_IDENT = 3'd6,
    MD_RSVD  = 3'd7
  } fmode_e;

  localparam logic [7:0] ID_MAKER   = 8'h1E;
  localparam logic [7:0] ID_DEVICE  = 8'h51;
  localparam logic [7:0] ID_VPP_HI  = 8'hFF;
  localparam logic [7:0] ID_VPP_LO  = 8'h05;
  localparam logic [7:0] BLANK_BYTE = 8'hFF;
endpackage

// File: rtl/flash_cell_array.sv
`timescale 1ns/1ps
module flash_cell_array
  import flash_seq_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          erase
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]       mem_q [DEPTH];
  logic [DEPTH-1:0] blank_q;
  logic             accept;

  // a cell only takes data while it is still blank
  assign accept = wr_en && !erase && blank_q[wr_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       blank_q <= '1;
    else if (erase)   blank_q <= '1;
    else if (accept)  blank_q[wr_addr] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (accept) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = blank_q[rd_addr] ? BLANK_BYTE : mem_q[rd_addr];

  // R5
  nonblank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase && !blank_q[wr_addr] && rd_addr == wr_addr) ##1
    (rd_addr == $past(rd_addr) && !erase) |-> $stable(rd_data));
endmodule

// File: rtl/flash_seq_ctrl.sv
`timescale 1ns/1ps
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int AW        = 12,
  parameter int WRITE_CYC = 300000,
  parameter int ERASE_CYC = 2000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fmode_e        mode_i,
  input  logic          hv_en_i,
  input  logic          prog_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    din_i,
  output logic          busy_o,
  output logic [AW-1:0] lat_addr_o,
  output logic [7:0]    lat_data_o,
  output logic          cell_wr_o,
  output logic          erase_o,
  output logic          locked_o
);
  localparam int CNT_W  = $clog2(WRITE_CYC + 1);
  localparam int ECNT_W = $clog2(ERASE_CYC + 1);

  logic              busy_q;
  fmode_e            kind_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ECNT_W-1:0] ecnt_q;
  logic              prog_q;
  logic [1:0]        lock_q;
  logic [AW-1:0]     lat_addr_q;
  logic [7:0]        lat_data_q;

  logic strobe_fall, timed_cmd, start, done, erase_hold, erase_go;

  always_comb begin
    strobe_fall = prog_q && !prog_n_i;
    timed_cmd   = (mode_i == MD_WRITE) || (mode_i == MD_LOCKA) || (mode_i == MD_LOCKB);
    start       = !busy_q && strobe_fall && hv_en_i && timed_cmd;
    done        = busy_q && (cnt_q == '0);
    erase_hold  = !busy_q && (mode_i == MD_ERASE) && hv_en_i && !prog_n_i;
    erase_go    = erase_hold && (ecnt_q == ECNT_W'(ERASE_CYC - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      kind_q     <= MD_IDLE;
      cnt_q      <= '0;
      ecnt_q     <= '0;
      prog_q     <= 1'b1;
      lock_q     <= '0;
      lat_addr_q <= '0;
      lat_data_q <= '0;
    end else begin
      prog_q <= prog_n_i;
      if (start) begin
        busy_q     <= 1'b1;
        kind_q     <= mode_i;
        cnt_q      <= CNT_W'(WRITE_CYC - 1);
        lat_addr_q <= addr_i;
        lat_data_q <= din_i;
      end else if (done) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end

      if (erase_hold) begin
        if (ecnt_q < ECNT_W'(ERASE_CYC)) ecnt_q <= ecnt_q + ECNT_W'(1);
      end else begin
        ecnt_q <= '0;
      end

      if (erase_go)                        lock_q    <= '0;
      else if (done && kind_q == MD_LOCKA) lock_q[0] <= 1'b1;
      else if (done && kind_q == MD_LOCKB) lock_q[1] <= 1'b1;
    end
  end

  assign busy_o     = busy_q;
  assign lat_addr_o = lat_addr_q;
  assign lat_data_o = lat_data_q;
  assign cell_wr_o  = done && (kind_q == MD_WRITE);
  assign erase_o    = erase_go;
  assign locked_o   = |lock_q;

  // R7
  busy_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !prog_n_i && prog_q) |=> $stable(lat_addr_q));

  // R6
  erase_long_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> ($past(!prog_n_i) && !prog_n_i && hv_en_i));
endmodule

// File: rtl/flash_read_path.sv
`timescale 1ns/1ps
module flash_read_path
  import flash_seq_pkg::*;
#(
  parameter int AW       = 12,
  parameter bit VPP_HIGH = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fmode_e        mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic          busy_i,
  input  logic [AW-1:0] lat_addr_i,
  input  logic          lat_bit7_i,
  input  logic          locked_i,
  input  logic [7:0]    cell_i,
  output logic [7:0]    dout_o
);
  logic [7:0] id_vpp;
  logic [7:0] dout_d, dout_q;

  if (VPP_HIGH) begin : g_vpp_hi
    assign id_vpp = ID_VPP_HI;
  end else begin : g_vpp_lo
    assign id_vpp = ID_VPP_LO;
  end

  always_comb begin
    dout_d = 8'h00;
    if (busy_i) begin
      if (mode_i == MD_READ && addr_i == lat_addr_i) dout_d = {~lat_bit7_i, 7'b0};
    end else begin
      case (mode_i)
        MD_READ:  dout_d = locked_i ? 8'h00 : cell_i;
        MD_IDENT: begin
          if (addr_i == AW'('h30))      dout_d = ID_MAKER;
          else if (addr_i == AW'('h31)) dout_d = ID_DEVICE;
          else if (addr_i == AW'('h32)) dout_d = id_vpp;
        end
        default:  dout_d = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= 8'h00;
    else        dout_q <= dout_d;
  end

  assign dout_o = dout_q;

  // R3
  poll_other_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !(mode_i == MD_READ && addr_i == lat_addr_i)) |=> dout_q == 8'h00);

  // R9
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_i && !busy_i && mode_i == MD_READ) |=> dout_q == 8'h00);

  // R10
  ident_maker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && mode_i == MD_IDENT && addr_i == AW'('h30)) |=> dout_q == ID_MAKER);
endmodule

// File: rtl/flash_prog_seq.sv
`timescale 1ns/1ps
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int AW        = 12,
  parameter int WRITE_CYC = 300000,
  parameter int ERASE_CYC = 2000000,
  parameter bit VPP_HIGH  = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    din_i,
  input  logic [2:0]    mode_i,
  input  logic          hv_en_i,
  input  logic          prog_n_i,
  output logic [7:0]    dout_o,
  output logic          rdy_o
);
  fmode_e        mode_e;
  logic          busy;
  logic [AW-1:0] lat_addr;
  logic [7:0]    lat_data;
  logic          cell_wr, erase, locked;
  logic [7:0]    cell_rd;

  assign mode_e = fmode_e'(mode_i);

  flash_seq_ctrl #(.AW(AW), .WRITE_CYC(WRITE_CYC), .ERASE_CYC(ERASE_CYC)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_e), .hv_en_i(hv_en_i), .prog_n_i(prog_n_i),
    .addr_i(addr_i), .din_i(din_i), .busy_o(busy), .lat_addr_o(lat_addr),
    .lat_data_o(lat_data), .cell_wr_o(cell_wr), .erase_o(erase), .locked_o(locked)
  );

  flash_cell_array #(.AW(AW)) array_i (
    .clk(clk), .rst_n(rst_n), .rd_addr(addr_i), .rd_data(cell_rd),
    .wr_en(cell_wr), .wr_addr(lat_addr), .wr_data(lat_data), .erase(erase)
  );

  flash_read_path #(.AW(AW), .VPP_HIGH(VPP_HIGH)) rdpath_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_e), .addr_i(addr_i), .busy_i(busy),
    .lat_addr_i(lat_addr), .lat_bit7_i(lat_data[7]), .locked_i(locked),
    .cell_i(cell_rd), .dout_o(dout_o)
  );

  assign rdy_o = !busy;

  // R2
  busy_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_o) |-> $past(!prog_n_i && hv_en_i));
endmodule

// File: tb/flash_prog_seq_tb.sv
`timescale 1ns/1ps
module flash_prog_seq_tb_top;
  localparam int AW = 12;
  localparam int WC = 20;
  localparam int EC = 50;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = 8'h00;
  logic [2:0] mode = 3'd0;
  logic hv = 1'b0;
  logic pn = 1'b1;
  logic [7:0] dout;
  logic rdy;

  int n_chk = 0;
  int n_bad = 0;
  bit run = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flash_prog_seq #(.AW(AW), .WRITE_CYC(WC), .ERASE_CYC(EC), .VPP_HIGH(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .din_i(din), .mode_i(mode),
    .hv_en_i(hv), .prog_n_i(pn), .dout_o(dout), .rdy_o(rdy)
  );

  // behavioural reference model
  byte unsigned m_mem [DEPTH];
  bit m_blank [DEPTH];
  bit m_lka, m_lkb, m_busy, m_prev;
  int m_cnt, m_ecnt;
  int m_la, m_ld, m_kind;
  logic [7:0] e_dout = 8'h00;
  bit e_rdy = 1'b1;

  function automatic logic [7:0] model_read();
    int a = int'(addr);
    if (m_busy) return (mode == 3'd2 && a == m_la) ? {~m_ld[7], 7'b0} : 8'h00;
    case (mode)
      3'd2: return (m_lka || m_lkb) ? 8'h00 : (m_blank[a] ? 8'hFF : m_mem[a]);
      3'd6: return (a == 'h30) ? 8'h1E : (a == 'h31) ? 8'h51 : (a == 'h32) ? 8'hFF : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) m_blank[i] = 1'b1;
      m_lka = 0; m_lkb = 0; m_busy = 0; m_prev = 1; m_cnt = 0; m_ecnt = 0;
      e_dout = 8'h00; e_rdy = 1'b1;
    end else begin
      logic [7:0] nd;
      bit fall;
      nd = model_read();
      fall = m_prev && !pn;
      if (m_busy) begin
        m_ecnt = 0;
        if (m_cnt == 0) begin
          m_busy = 0;
          if (m_kind == 1 && m_blank[m_la]) begin m_mem[m_la] = m_ld[7:0]; m_blank[m_la] = 0; end
          else if (m_kind == 4) m_lka = 1;
          else if (m_kind == 5) m_lkb = 1;
        end else m_cnt--;
      end else begin
        if (fall && hv && (mode == 3'd1 || mode == 3'd4 || mode == 3'd5)) begin
          m_busy = 1; m_cnt = WC - 1; m_la = int'(addr); m_ld = int'(din); m_kind = int'(mode);
        end
        if (mode == 3'd3 && hv && !pn) begin
          if (m_ecnt == EC - 1) begin
            for (int i = 0; i < DEPTH; i++) m_blank[i] = 1'b1;
            m_lka = 0; m_lkb = 0;
          end
          if (m_ecnt < EC) m_ecnt++;
        end else m_ecnt = 0;
      end
      m_prev = pn;
      e_dout = nd;
      e_rdy = !m_busy;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run) begin
      chk("R2 cycle model rdy", 32'(rdy), 32'(e_rdy));
      chk("R4 cycle model dout", 32'(dout), 32'(e_dout));
    end
  end

  task automatic drive(input logic [2:0] m, input logic [AW-1:0] a, input logic [7:0] d,
                       input logic h, input logic p);
    @(negedge clk);
    mode = m; addr = a; din = d; hv = h; pn = p;
  endtask

  task automatic rd(input logic [2:0] m, input logic [AW-1:0] a, output logic [7:0] v);
    drive(m, a, 8'h00, 1'b0, 1'b1);
    @(negedge clk);
    v = dout;
  endtask

  task automatic pulse(input logic [2:0] m, input logic [AW-1:0] a, input logic [7:0] d,
                       input logic h, output int blen);
    drive(m, a, d, h, 1'b1);
    drive(m, a, d, h, 1'b0);
    drive(3'd0, a, d, h, 1'b1);
    blen = 0;
    while (rdy == 1'b0 && blen < 1000) begin
      blen++;
      @(negedge clk);
    end
  endtask

  task automatic hold_erase(input int n, input logic h);
    drive(3'd3, '0, 8'h00, h, 1'b0);
    repeat (n - 1) @(negedge clk);
    drive(3'd0, '0, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int blen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 rdy after reset", 32'(rdy), 32'd1);
    chk("R1 dout after reset", 32'(dout), 32'h00);
    rd(3'd2, 12'h000, v); chk("R1 blank at 000", 32'(v), 32'hFF);
    rd(3'd2, 12'hFFF, v); chk("R1 blank at FFF", 32'(v), 32'hFF);

    // R2 and R3: write with polling
    drive(3'd1, 12'h123, 8'h3C, 1'b1, 1'b1);
    drive(3'd1, 12'h123, 8'h3C, 1'b1, 1'b0);
    drive(3'd2, 12'h123, 8'h00, 1'b1, 1'b1);
    chk("R2 busy after strobe", 32'(rdy), 32'd0);
    @(negedge clk);
    chk("R3 polled bit7 inverted", 32'(dout), 32'h80);
    drive(3'd2, 12'h124, 8'h00, 1'b1, 1'b1);
    @(negedge clk);
    chk("R3 other address while busy", 32'(dout), 32'h00);
    while (!rdy) @(negedge clk);
    rd(3'd2, 12'h123, v); chk("R4 data after write", 32'(v), 32'h3C);

    pulse(3'd1, 12'h050, 8'hC3, 1'b1, blen);
    chk("R2 busy length", 32'(blen), 32'(WC));
    rd(3'd2, 12'h050, v); chk("R4 second write", 32'(v), 32'hC3);

    // R7: strobe while busy
    begin
      int cnt = 0;
      drive(3'd1, 12'h200, 8'h11, 1'b1, 1'b1);
      drive(3'd1, 12'h200, 8'h11, 1'b1, 1'b0);
      drive(3'd0, 12'h200, 8'h11, 1'b1, 1'b1); if (!rdy) cnt++;
      drive(3'd1, 12'h201, 8'h22, 1'b1, 1'b1); if (!rdy) cnt++;
      drive(3'd1, 12'h201, 8'h22, 1'b1, 1'b0); if (!rdy) cnt++;
      drive(3'd3, 12'h201, 8'h22, 1'b1, 1'b0); if (!rdy) cnt++;
      drive(3'd0, 12'h201, 8'h22, 1'b1, 1'b1); if (!rdy) cnt++;
      forever begin
        @(negedge clk);
        if (rdy) break;
        cnt++;
      end
      chk("R7 busy not extended", 32'(cnt), 32'(WC));
      rd(3'd2, 12'h201, v); chk("R7 second address untouched", 32'(v), 32'hFF);
      rd(3'd2, 12'h200, v); chk("R7 first write landed", 32'(v), 32'h11);
    end

    // R8
    pulse(3'd1, 12'h300, 8'h77, 1'b0, blen);
    chk("R8 no busy without hv", 32'(blen), 32'd0);
    rd(3'd2, 12'h300, v); chk("R8 cell blank without hv", 32'(v), 32'hFF);
    hold_erase(EC + 5, 1'b0);
    rd(3'd2, 12'h123, v); chk("R8 erase without hv ignored", 32'(v), 32'h3C);

    // R6
    hold_erase(EC - 1, 1'b1);
    rd(3'd2, 12'h123, v); chk("R6 short hold no erase", 32'(v), 32'h3C);
    hold_erase(EC, 1'b1);
    rd(3'd2, 12'h123, v); chk("R6 erased 123", 32'(v), 32'hFF);
    rd(3'd2, 12'h200, v); chk("R6 erased 200", 32'(v), 32'hFF);

    // R5
    pulse(3'd1, 12'h123, 8'h5A, 1'b1, blen);
    rd(3'd2, 12'h123, v); chk("R5 rewrite after erase", 32'(v), 32'h5A);
    pulse(3'd1, 12'h123, 8'h00, 1'b1, blen);
    chk("R5 busy on nonblank", 32'(blen), 32'(WC));
    rd(3'd2, 12'h123, v); chk("R5 nonblank unchanged", 32'(v), 32'h5A);

    // R10
    rd(3'd6, 12'h030, v); chk("R10 id 030", 32'(v), 32'h1E);
    rd(3'd6, 12'h031, v); chk("R10 id 031", 32'(v), 32'h51);
    rd(3'd6, 12'h032, v); chk("R10 id 032", 32'(v), 32'hFF);
    rd(3'd6, 12'h033, v); chk("R10 id 033", 32'(v), 32'h00);

    // R9
    pulse(3'd4, 12'h000, 8'h00, 1'b1, blen);
    chk("R9 lock A busy", 32'(blen), 32'(WC));
    rd(3'd2, 12'h123, v); chk("R9 read blocked A", 32'(v), 32'h00);
    rd(3'd6, 12'h030, v); chk("R9 id under lock", 32'(v), 32'h1E);
    hold_erase(EC, 1'b1);
    rd(3'd2, 12'h123, v); chk("R9 erase clears lock", 32'(v), 32'hFF);
    pulse(3'd1, 12'h010, 8'h99, 1'b1, blen);
    pulse(3'd5, 12'h000, 8'h00, 1'b1, blen);
    chk("R9 lock B busy", 32'(blen), 32'(WC));
    rd(3'd2, 12'h010, v); chk("R9 read blocked B", 32'(v), 32'h00);
    hold_erase(EC, 1'b1);
    rd(3'd2, 12'h010, v); chk("R9 erased after B", 32'(v), 32'hFF);

    // R11
    rd(3'd0, 12'h030, v); chk("R11 idle mode zero", 32'(v), 32'h00);
    rd(3'd7, 12'h030, v); chk("R11 reserved mode zero", 32'(v), 32'h00);
    pulse(3'd2, 12'h040, 8'h12, 1'b1, blen);
    chk("R11 strobe in read mode", 32'(blen), 32'd0);
    rd(3'd2, 12'h040, v); chk("R11 no write from read mode", 32'(v), 32'hFF);

    repeat (2) @(negedge clk);
    finished = 1'b1;
    report();
    $finish;
  end
endmodule